// File: doc/BRIEF.md
# Carrier Oscillator with Quadrature Up-Mixer

This block turns a stream of baseband sample pairs (in-phase and quadrature, 14-bit signed) into a single real stream on a digital carrier. A 32-bit phase accumulator steps once for every accepted sample pair. Its top bits, plus a programmable 16-bit phase offset, address a sine/cosine table. Each output sample is the in-phase value times the cosine, combined with the quadrature value times the sine. By default the sine product is subtracted; a mode bit adds it instead, which picks the other sideband. The result is rounded, optionally scaled down by about 3 dB, and saturated to 14 bits.

Configuration arrives as byte writes on a plain write port. The frequency and the phase offset are assembled from several bytes, and a new value takes effect only when its final byte is written. A reduced-resolution mode keeps only the top five bits of the accumulator, the frequency step and the phase offset. In that mode the carrier lands on a coarse grid of 32 phases per turn. The sample streams use valid/ready handshakes. An input pair is accepted on any clock edge where both `s_valid` and `s_ready` are high. A result leaves on any edge where both `m_valid` and `m_ready` are high. While `m_ready` is low, the output holds, and once both pipeline stages are full the input stalls.

Top module: `nco_qmod`

## Requirements
- R1: Addresses 0, 1 and 2 hold bytes 0 to 2 (least significant first) of the frequency step in a staging copy that has no effect on the output. A write to address 3 loads the full 32-bit step as {byte written, staged bytes 2..0}, and samples accepted on later edges use it.
- R2: The 16-bit phase offset covers one full turn. A write to address 4 stages its low byte. A write to address 5 loads {byte written, staged low byte}, and samples accepted on later edges use it.
- R3: The accumulator is zero after reset. The table index for an accepted pair is bits 31..26 of (accumulator + offset·2^16). On that same edge the accumulator advances by the frequency step, so the carrier runs at step·fs/2^32, where fs is the accepted pair rate. Without an accepted pair the accumulator holds.
- R4: The table has 64 points per turn. sine(k) = round(8191·sin(2πk/64)) and cosine(k) = sine((k+16) mod 64).
- R5: With the sine-invert bit clear, the output is floor((I·cos − Q·sin + 4096) / 8192).
- R6: With the sine-invert bit set, the output is floor((I·cos + Q·sin + 4096) / 8192).
- R7: With the gain-cut bit set, the R5/R6 result y becomes floor((181·y + 128) / 256).
- R8: The output is saturated to the range −8192 to 8191.
- R9: In the reduced-resolution mode, the accumulator, the step (bits 31..27) and the offset (bits 15..11) are each used with their lower bits cleared, so the table index is always even.
- R10: No pair is lost or duplicated and order is kept. A result appears on `m_valid` at the second rising edge after acceptance. `m_data` holds while `m_valid` is high and `m_ready` is low, and `s_ready` is low only when `m_valid` is high and `m_ready` is low.
- R11: Address 6 is the mode byte: bit 0 selects reduced resolution, bit 1 is sine-invert and bit 2 is gain-cut. The mode a pair sees is the one in place when the pair is accepted. Writes to address 7 change nothing.
- R12: After reset `m_valid` is low, `s_ready` is high, and the step, offset and mode are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | ADDR_W (3) | Configuration byte address |
| cfg_data | input | 8 | Configuration byte value |
| s_valid | input | 1 | Input pair valid |
| s_ready | output | 1 | Input pair can be taken |
| s_i | input | 14 | In-phase sample, signed |
| s_q | input | 14 | Quadrature sample, signed |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream can take the output |
| m_data | output | 14 | Modulated sample, signed |

## Verification
The assertions check on every cycle that the frequency step and the phase offset change only on a write to their final byte, and that the accumulator moves only on an accepted pair. They also check that the table index stays even in reduced-resolution mode, and that the output handshake holds its data and stalls the input correctly. The arithmetic can only be shown by the bench's scenarios, which compare every result against an independent model: the table values, both sideband signs, rounding, the gain step and saturation at both rails. The same applies to staged bytes having no effect, to an offset of a quarter turn, to the coarse grid of the reduced mode, and to loss-free ordering under random back-pressure.

// File: rtl/nco_qmod_pkg.sv
package nco_qmod_pkg;
  // sample width on both the baseband and modulated streams
  localparam int SAMPLE_W  = 14;
  // table index width: points per turn = 2**IDX_W
  localparam int IDX_W     = 6;
  localparam int QTR_PTS   = 2 ** (IDX_W - 2);
  // table amplitude scale (fractional bits of the trig values)
  localparam int TRIG_FRAC = SAMPLE_W - 1;
  // gain-cut ratio GAIN_NUM / 2**GAIN_SH (about -3 dB)
  localparam int GAIN_NUM  = 181;
  localparam int GAIN_SH   = 8;
  // mode byte bit positions
  localparam int MODE_LP   = 0;
  localparam int MODE_INV  = 1;
  localparam int MODE_CUT  = 2;

  typedef struct packed {
    logic signed [SAMPLE_W-1:0] i;
    logic signed [SAMPLE_W-1:0] q;
    logic signed [SAMPLE_W-1:0] sn;
    logic signed [SAMPLE_W-1:0] cs;
    logic                       inv;
    logic                       cut;
  } mix_in_t;
endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  output logic [FREQ_W-1:0]  freq_word,
  output logic [PHASE_W-1:0] phase_off,
  output logic               lp_mode,
  output logic               sin_inv,
  output logic               gain_cut
);
  import nco_qmod_pkg::*;

  localparam int F_BYTES   = FREQ_W / 8;
  localparam int P_BYTES   = PHASE_W / 8;
  localparam int F_LAST    = F_BYTES - 1;
  localparam int P_BASE    = F_BYTES;
  localparam int P_LAST    = F_BYTES + P_BYTES - 1;
  localparam int MODE_ADDR = F_BYTES + P_BYTES;

  logic [FREQ_W-9:0]  f_stage;
  logic [PHASE_W-9:0] p_stage;
  logic [7:0]         mode_q;

  // lower bytes go to staging copies; the final byte commits the whole word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_stage   <= '0;
      p_stage   <= '0;
      freq_word <= '0;
      phase_off <= '0;
      mode_q    <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < F_LAST; b++) begin
        if (wr_addr == ADDR_W'(b)) f_stage[b*8 +: 8] <= wr_data;
      end
      for (int b = 0; b < P_BYTES - 1; b++) begin
        if (wr_addr == ADDR_W'(P_BASE + b)) p_stage[b*8 +: 8] <= wr_data;
      end
      if (wr_addr == ADDR_W'(F_LAST))    freq_word <= {wr_data, f_stage};
      if (wr_addr == ADDR_W'(P_LAST))    phase_off <= {wr_data, p_stage};
      if (wr_addr == ADDR_W'(MODE_ADDR)) mode_q    <= wr_data;
    end
  end

  assign lp_mode  = mode_q[MODE_LP];
  assign sin_inv  = mode_q[MODE_INV];
  assign gain_cut = mode_q[MODE_CUT];
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int LP_BITS = 5,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               lp_mode,
  input  logic [FREQ_W-1:0]  freq_word,
  input  logic [PHASE_W-1:0] phase_off,
  output logic [FREQ_W-1:0]  acc_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam logic [FREQ_W-1:0]  F_MASK = ~({FREQ_W{1'b1}} >> LP_BITS);
  localparam logic [PHASE_W-1:0] P_MASK = ~({PHASE_W{1'b1}} >> LP_BITS);
  localparam int                 P_SH   = FREQ_W - PHASE_W;

  logic [FREQ_W-1:0]  acc_q;
  logic [FREQ_W-1:0]  acc_use;
  logic [FREQ_W-1:0]  step_use;
  logic [PHASE_W-1:0] off_use;
  logic [FREQ_W-1:0]  phase_sum;

  always_comb begin
    acc_use   = lp_mode ? (acc_q & F_MASK) : acc_q;
    step_use  = lp_mode ? (freq_word & F_MASK) : freq_word;
    off_use   = lp_mode ? (phase_off & P_MASK) : phase_off;
    phase_sum = acc_use + {off_use, {P_SH{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (advance) acc_q <= acc_use + step_use;
  end

  assign acc_o = acc_q;
  assign idx_o = phase_sum[FREQ_W-1 -: IDX_W];
endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
  import nco_qmod_pkg::*;
(
  input  logic [IDX_W-1:0]           idx,
  output logic signed [SAMPLE_W-1:0] sin_o,
  output logic signed [SAMPLE_W-1:0] cos_o
);
  // first quadrant, inclusive of both end points
  function automatic logic [SAMPLE_W-2:0] qtab(input logic [IDX_W-2:0] k);
    case (k)
      5'd0:    qtab = 13'd0;
      5'd1:    qtab = 13'd803;
      5'd2:    qtab = 13'd1598;
      5'd3:    qtab = 13'd2378;
      5'd4:    qtab = 13'd3135;
      5'd5:    qtab = 13'd3861;
      5'd6:    qtab = 13'd4551;
      5'd7:    qtab = 13'd5196;
      5'd8:    qtab = 13'd5792;
      5'd9:    qtab = 13'd6332;
      5'd10:   qtab = 13'd6811;
      5'd11:   qtab = 13'd7224;
      5'd12:   qtab = 13'd7567;
      5'd13:   qtab = 13'd7838;
      5'd14:   qtab = 13'd8034;
      5'd15:   qtab = 13'd8152;
      default: qtab = 13'd8191;
    endcase
  endfunction

  // fold a full-turn index onto the quadrant table
  function automatic logic signed [SAMPLE_W-1:0] wave(input logic [IDX_W-1:0] p);
    logic [IDX_W-2:0] fine;
    logic [IDX_W-2:0] k;
    logic [SAMPLE_W-2:0] mag;
    fine = {1'b0, p[IDX_W-3:0]};
    k    = p[IDX_W-2] ? (IDX_W-1)'(QTR_PTS) - fine : fine;
    mag  = qtab(k);
    wave = p[IDX_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction

  logic signed [SAMPLE_W-1:0] vals [2];

  // lane 0 reads the sine, lane 1 the cosine a quarter turn ahead
  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [IDX_W-1:0] lane_idx;
    assign lane_idx = idx + IDX_W'(ln * QTR_PTS);
    assign vals[ln] = wave(lane_idx);
  end

  assign sin_o = vals[0];
  assign cos_o = vals[1];
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_qmod_pkg::*;
(
  input  mix_in_t                    x,
  output logic signed [SAMPLE_W-1:0] y
);
  localparam int PW = 2 * SAMPLE_W + 4;
  localparam logic signed [PW-1:0] HALF  = PW'(2 ** (TRIG_FRAC - 1));
  localparam logic signed [PW-1:0] G_NUM = PW'(GAIN_NUM);
  localparam logic signed [PW-1:0] G_RND = PW'(2 ** (GAIN_SH - 1));
  localparam logic signed [PW-1:0] MAXV  = PW'(2 ** (SAMPLE_W - 1) - 1);
  localparam logic signed [PW-1:0] MINV  = -PW'(2 ** (SAMPLE_W - 1));

  function automatic logic signed [PW-1:0] sx(input logic signed [SAMPLE_W-1:0] v);
    sx = {{(PW - SAMPLE_W){v[SAMPLE_W-1]}}, v};
  endfunction

  logic signed [PW-1:0] p_i, p_q, p_sum, p_rnd, p_gain;

  always_comb begin
    p_i    = sx(x.i) * sx(x.cs);
    p_q    = sx(x.q) * sx(x.sn);
    p_sum  = x.inv ? (p_i + p_q) : (p_i - p_q);
    p_rnd  = (p_sum + HALF) >>> TRIG_FRAC;
    p_gain = x.cut ? ((p_rnd * G_NUM + G_RND) >>> GAIN_SH) : p_rnd;
    if (p_gain > MAXV)      y = MAXV[SAMPLE_W-1:0];
    else if (p_gain < MINV) y = MINV[SAMPLE_W-1:0];
    else                    y = p_gain[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/nco_qmod.sv
module nco_qmod
  import nco_qmod_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int LP_BITS = 5,
  parameter int ADDR_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr_en,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [7:0]                 cfg_data,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_i,
  input  logic signed [SAMPLE_W-1:0] s_q,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic signed [SAMPLE_W-1:0] m_data
);
  logic [FREQ_W-1:0]  freq_word;
  logic [PHASE_W-1:0] phase_off;
  logic               lp_mode, sin_inv, gain_cut;
  logic [FREQ_W-1:0]  acc_state;
  logic [IDX_W-1:0]   lut_idx;
  logic signed [SAMPLE_W-1:0] sin_v, cos_v, mix_y;

  logic    st1_v, st2_v;
  mix_in_t st1_q;
  logic signed [SAMPLE_W-1:0] st2_y;
  logic    st1_open, st2_open, take, move;

  nco_cfg_regs #(
    .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_data),
    .freq_word(freq_word), .phase_off(phase_off),
    .lp_mode(lp_mode), .sin_inv(sin_inv), .gain_cut(gain_cut)
  );

  nco_phase_acc #(
    .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .LP_BITS(LP_BITS), .IDX_W(IDX_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .advance(take), .lp_mode(lp_mode),
    .freq_word(freq_word), .phase_off(phase_off),
    .acc_o(acc_state), .idx_o(lut_idx)
  );

  nco_sincos_lut u_lut (
    .idx(lut_idx), .sin_o(sin_v), .cos_o(cos_v)
  );

  nco_mixer u_mix (
    .x(st1_q), .y(mix_y)
  );

  // two-stage pipeline: stage 1 holds operands, stage 2 holds the result
  assign st2_open = !st2_v || m_ready;
  assign st1_open = !st1_v || st2_open;
  assign take     = s_valid && st1_open;
  assign move     = st1_v && st2_open;
  assign s_ready  = st1_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1_v <= 1'b0;
      st1_q <= '0;
    end else begin
      if (st1_open) st1_v <= s_valid;
      if (take) begin
        st1_q.i   <= s_i;
        st1_q.q   <= s_q;
        st1_q.sn  <= sin_v;
        st1_q.cs  <= cos_v;
        st1_q.inv <= sin_inv;
        st1_q.cut <= gain_cut;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st2_v <= 1'b0;
      st2_y <= '0;
    end else begin
      if (st2_open) st2_v <= st1_v;
      if (move)     st2_y <= mix_y;
    end
  end

  assign m_valid = st2_v;
  assign m_data  = st2_y;
endmodule

// File: rtl/nco_qmod_checks.sv
module nco_qmod_checks #(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 3,
  parameter int IDX_W   = 6,
  parameter int DW      = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr_en,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic               s_valid,
  input logic               s_ready,
  input logic               m_valid,
  input logic               m_ready,
  input logic [DW-1:0]      m_data,
  input logic [FREQ_W-1:0]  freq_word,
  input logic [PHASE_W-1:0] phase_off,
  input logic [FREQ_W-1:0]  acc_state,
  input logic [IDX_W-1:0]   lut_idx,
  input logic               lp_mode
);
  localparam int F_LAST = FREQ_W / 8 - 1;
  localparam int P_LAST = FREQ_W / 8 + PHASE_W / 8 - 1;

  // R1: step word changes only on a write to its final byte
  p_freq_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_addr == ADDR_W'(F_LAST)) |=> $stable(freq_word));

  // R2: phase offset changes only on a write to its high byte
  p_phase_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_addr == ADDR_W'(P_LAST)) |=> $stable(phase_off));

  // R3: accumulator moves only on an accepted pair
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(acc_state));

  // R9: reduced resolution keeps the table index even
  p_lp_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lp_mode |-> (lut_idx[0] == 1'b0));

  // R10: output holds under back-pressure
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R10: input stalls only when the output is blocked
  p_stall_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (m_valid && !m_ready));
endmodule

bind nco_qmod nco_qmod_checks #(
  .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W),
  .IDX_W(nco_qmod_pkg::IDX_W), .DW(nco_qmod_pkg::SAMPLE_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .s_valid(s_valid), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .freq_word(freq_word), .phase_off(phase_off),
  .acc_state(acc_state), .lut_idx(lut_idx), .lp_mode(lp_mode)
);

// File: tb/nco_qmod_bench.sv
module nco_qmod_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [13:0] s_i = '0, s_q = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic signed [13:0] m_data;

  always #5 clk = ~clk;

  nco_qmod u_nco_qmod (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i),
    .s_q(s_q), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // bench-side model of the programmed state
  logic [31:0] md_freq = 0, md_acc = 0;
  logic [23:0] md_fst = 0;
  logic [15:0] md_off = 0;
  logic [7:0]  md_plo = 0, md_mode = 0;

  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R5";

  bit bp_en = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int trig(input int k);
    real r;
    r = 8191.0 * $sin(2.0 * 3.14159265358979 * real'(k % 64) / 64.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic int expect_y(input int i, input int q, input int k,
                                  input bit inv, input bit cut);
    longint p, y;
    p = longint'(i) * trig(k + 16) + (inv ? 1 : -1) * longint'(q) * trig(k);
    y = (p + 4096) >>> 13;
    if (cut) y = (y * 181 + 128) >>> 8;
    if (y > 8191) y = 8191;
    if (y < -8192) y = -8192;
    return int'(y);
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = a; cfg_data = d;
    @(posedge clk);
    #1 cfg_wr_en = 0;
    case (a)
      3'd0: md_fst[7:0]   = d;
      3'd1: md_fst[15:8]  = d;
      3'd2: md_fst[23:16] = d;
      3'd3: md_freq       = {d, md_fst};
      3'd4: md_plo        = d;
      3'd5: md_off        = {d, md_plo};
      3'd6: md_mode       = d;
      default: ;
    endcase
  endtask

  task automatic set_freq(input logic [31:0] f);
    for (int b = 0; b < 4; b++) cfg_write(3'(b), f[b*8 +: 8]);
  endtask

  task automatic set_off(input logic [15:0] o);
    cfg_write(3'd4, o[7:0]);
    cfg_write(3'd5, o[15:8]);
  endtask

  task automatic send(input int i, input int q);
    logic [31:0] au, st, sum;
    logic [15:0] ou;
    int k;
    @(negedge clk);
    s_valid = 1; s_i = 14'(i); s_q = 14'(q);
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    au  = md_mode[0] ? (md_acc & 32'hF800_0000) : md_acc;
    st  = md_mode[0] ? (md_freq & 32'hF800_0000) : md_freq;
    ou  = md_mode[0] ? (md_off & 16'hF800) : md_off;
    sum = au + {ou, 16'h0};
    k   = int'(sum[31:26]);
    exp_q.push_back(expect_y(i, q, k, md_mode[1], md_mode[2]));
    tag_q.push_back(cur_tag);
    md_acc = au + st;
    @(posedge clk);
    #1 s_valid = 0;
  endtask

  task automatic burst(input int n, input int seed);
    for (int k = 0; k < n; k++)
      send(((k * 1237 + seed) % 16384) - 8192, ((k * 3571 + seed * 7) % 16384) - 8192);
  endtask

  // downstream readiness
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // scoreboard monitor
  bit prev_stall = 0;
  logic signed [13:0] prev_data = 0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) check("R10 hold", int'(m_data), int'(prev_data));
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) check("R10 extra output", 1, 0);
        else check(tag_q.pop_front(), int'(m_data), exp_q.pop_front());
      end
      prev_stall = m_valid && !m_ready;
      prev_data  = m_data;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check("R12 s_ready", int'(s_ready), 1);
    check("R12 m_valid", int'(m_valid), 0);

    // R10 latency, R12 zero step and offset: idx 0 gives cos=8191, sin=0
    cur_tag = "R12 zero state";
    send(1000, 500);
    @(negedge clk); #3;
    check("R10 latency first", int'(m_valid), 0);
    @(negedge clk); #3;
    check("R10 latency second", int'(m_valid), 1);
    repeat (3) @(negedge clk);

    // R3 R4 R5: one table step per sample, two full turns
    cur_tag = "R4 R5 sweep";
    set_freq(32'h0400_0000);
    burst(130, 11);

    // R1: staged bytes alone change nothing
    cur_tag = "R1 staged";
    cfg_write(3'd0, 8'hFF); cfg_write(3'd1, 8'hFF); cfg_write(3'd2, 8'hFF);
    burst(10, 3);
    cur_tag = "R1 committed";
    cfg_write(3'd3, 8'h08);
    burst(20, 5);

    // R2: quarter-turn offset, low byte staged first
    cur_tag = "R2 staged";
    cfg_write(3'd4, 8'h00);
    burst(5, 9);
    cur_tag = "R2 offset";
    cfg_write(3'd5, 8'h40);
    burst(20, 21);

    // R6 sine inverted
    cur_tag = "R6 invert";
    cfg_write(3'd6, 8'h02);
    burst(40, 33);

    // R8 saturation at 45 degrees, then R7 gain cut avoids the clip
    cur_tag = "R8 saturate";
    cfg_write(3'd6, 8'h00);
    set_freq(32'h0);
    set_off(16'h2000);
    send(8191, -8192);
    send(-8192, 8191);
    cur_tag = "R7 gain cut";
    cfg_write(3'd6, 8'h04);
    send(8191, -8192);
    send(-8192, 8191);
    burst(20, 41);

    // R9 reduced resolution: step bit 0 and offset bit 10 are dropped
    cur_tag = "R9 low power";
    cfg_write(3'd6, 8'h01);
    set_freq(32'h0C00_0001);
    set_off(16'h0C00);
    burst(40, 57);

    // R11 mode taken at acceptance; address 7 is ignored
    cur_tag = "R11 unused addr";
    cfg_write(3'd6, 8'h00);
    set_freq(32'h0123_4567);
    cfg_write(3'd7, 8'hFF);
    burst(20, 71);

    // R10 random back-pressure
    cur_tag = "R10 backpressure";
    bp_en = 1;
    cfg_write(3'd6, 8'h02);
    burst(200, 83);
    bp_en = 0;

    repeat (10) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule